// File: doc/BRIEF.md
# BT.656 Test Pattern Generator

This block produces an 8-bit 4:2:2 component video byte stream in the ITU-R BT.656 layout. It needs no external video source, so it is used to bring up and check a video path. Each line carries an end-of-active-video timing code, a horizontal blanking interval, a start-of-active-video timing code and 720 active pixels. The stream follows 525-line or 625-line frame timing, chosen by a single format bit.

The active picture carries one of eight built-in test images. These are colour bars, luma-only bars, a two-level luma step, a flat aqua field and four luma ramps with different slopes. Both the image and the format are taken only at frame boundaries, so a frame is never mixed. The horizontal and vertical geometry is fully parameterised. The defaults give the standard line and frame sizes, and a bench or a slow-speed derivative may shrink them.

Top module: `vpat656_gen`

## Requirements
- R1: A line is `2*ACT_PIX + HB + 8` bytes long, with HB = `HBLK_N` (268) in 525-line mode and `HBLK_P` (280) in 625-line mode, so the default line sizes are 1716 and 1728 bytes. Bytes 0..3 hold the end code, bytes 4..HB+3 are blanking, bytes HB+4..HB+7 hold the start code, and the remaining bytes are the active samples. Each timing code is the sequence FF, 00, 00, then a status word.
- R2: The status word is {1, F, V, H, V^H, F^H, F^V, F^V^H} from bit 7 down to bit 0. H is 1 in the end code and 0 in the start code.
- R3: Lines are numbered from 1, and a frame has `N_LINES` (525) or `P_LINES` (625) lines. F is 1 when line >= FS or line < FE. V is 1 when line < A1, or A1..: B1 <= line < A2, or line >= B2. The defaults for 525 lines are FS=266, FE=4, A1=20, B1=264, A2=283, B2=526. The defaults for 625 lines are FS=313, FE=1, A1=23, B1=311, A2=336, B2=624.
- R4: Every blanking byte, including the whole active span of lines with V=1, is 0x80 at an even byte offset within the line and 0x10 at an odd offset.
- R5: Active bytes repeat the sequence Cb, Y, Cr, Y. Pixel pair k gives Cb(2k), Y(2k), Cr(2k), Y(2k+1), so chroma is taken from the even pixel of each pair.
- R6: Colour bars give 8 bars, each ACT_PIX/8 pixels wide. From left to right the (Y, Cb, Cr) values in decimal are (169,128,128), (152,50,141), (123,154,50), (106,76,62), (79,180,194), (62,102,206), (33,206,115) and (16,128,128). These are the 70 % amplitude and saturation levels.
- R7: Luma bars use the same eight Y values as R6, with Cb = Cr = 128.
- R8: The luma step is Y=16 for pixels below ACT_PIX/2 and Y=169 from there on, with chroma 128.
- R9: The aqua field is Y=123, Cb=154, Cr=50 on every active pixel.
- R10: The ramps give Y(p) = min(16 + floor(p*s), 235) for pixel p of the line, with s = 1/2, 1, 2 or 4, and chroma 128. Each ramp restarts at 16 on every line.
- R11: The image is chosen by `pat_sel` with bit 3 = 0. Bits [2:0] select 0 colour bars, 1 luma bars, 2 step, 3 aqua, 4 ramp s=1/2, 5 s=1, 6 s=2 and 7 s=4. Any code with bit 3 = 1 gives a flat black field (Y=16, chroma 128). `fmt_pal` = 1 selects 625-line timing.
- R12: No active sample is ever 0x00 or 0xFF.
- R13: While reset is held, `dout` is 0x80. The first frame after reset is 525-line colour bars, whatever the inputs are. The values of `pat_sel` and `fmt_pal` present on the last byte of a frame govern the whole next frame, and changes at any other time have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte-rate clock (twice the pixel rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_sel | input | 4 | Test image code, see R11 |
| fmt_pal | input | 1 | 0 = 525-line timing, 1 = 625-line timing |
| dout | output | 8 | BT.656 byte stream |

## Verification
The sharpest coincidence is the last byte of a frame. In that cycle the line and byte counters wrap, and the new image and format registers load in the same edge. The first byte of the next frame must therefore already use the new line length and F/V table. The bench changes the inputs twice in every frame: a throwaway code early on, then the real code well before the boundary. It then predicts each byte of the following frame from the final code only, so any early or late capture shows as mismatches in the first line. A second coincidence is the saturation of the steepest ramp, which happens inside a pixel pair. The bench checks it at the exact pixel where 16+4p first passes 235.

// File: rtl/vpat656_pkg.sv
package vpat656_pkg;

   typedef enum logic [1:0] {
      Z_EAV,
      Z_BLANK,
      Z_SAV,
      Z_ACT
   } zone_e;

   typedef struct packed {
      logic [7:0] y;
      logic [7:0] cb;
      logic [7:0] cr;
   } ycc_t;

   localparam logic [7:0] Y_BLK     = 8'h10;
   localparam logic [7:0] Y_MAX     = 8'hEB;
   localparam logic [7:0] C_MID     = 8'h80;
   localparam logic [7:0] Y_STEP_HI = 8'hA9;

   // 70 % bars, white to black
   function automatic ycc_t bar_color(input logic [2:0] idx);
      ycc_t c;
      unique case (idx)
         3'd0: c = '{8'd169, 8'd128, 8'd128};
         3'd1: c = '{8'd152, 8'd50,  8'd141};
         3'd2: c = '{8'd123, 8'd154, 8'd50};
         3'd3: c = '{8'd106, 8'd76,  8'd62};
         3'd4: c = '{8'd79,  8'd180, 8'd194};
         3'd5: c = '{8'd62,  8'd102, 8'd206};
         3'd6: c = '{8'd33,  8'd206, 8'd115};
         default: c = '{8'd16, 8'd128, 8'd128};
      endcase
      return c;
   endfunction

   function automatic logic [7:0] xy_code(input logic f, input logic v, input logic h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

   function automatic logic [7:0] sample_clamp(input logic [7:0] s);
      if (s == 8'h00)      return 8'h01;
      else if (s == 8'hFF) return 8'hFE;
      else                 return s;
   endfunction

endpackage

// File: rtl/vpat656_timing.sv
module vpat656_timing
   import vpat656_pkg::*;
#(
   parameter int ACT_PIX = 720,
   parameter int HBLK_N  = 268,
   parameter int HBLK_P  = 280,
   parameter int N_LINES = 525,
   parameter int N_FS    = 266,
   parameter int N_FE    = 4,
   parameter int N_A1    = 20,
   parameter int N_B1    = 264,
   parameter int N_A2    = 283,
   parameter int N_B2    = 526,
   parameter int P_LINES = 625,
   parameter int P_FS    = 313,
   parameter int P_FE    = 1,
   parameter int P_A1    = 23,
   parameter int P_B1    = 311,
   parameter int P_A2    = 336,
   parameter int P_B2    = 624,
   parameter int HW      = 11,
   parameter int VW      = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fmt_in,
   input  logic [3:0]    pat_in,
   output logic          fmt_q,
   output logic [3:0]    pat_q,
   output zone_e         zone,
   output logic [HW-1:0] ofs,
   output logic          f_bit,
   output logic          v_bit,
   output logic          frame_end
);

   localparam int LEN_N = 2 * ACT_PIX + HBLK_N + 8;
   localparam int LEN_P = 2 * ACT_PIX + HBLK_P + 8;

   localparam logic [HW-1:0] LAST_N = HW'(LEN_N - 1);
   localparam logic [HW-1:0] LAST_P = HW'(LEN_P - 1);
   localparam logic [HW-1:0] SAVB_N = HW'(HBLK_N + 4);
   localparam logic [HW-1:0] SAVB_P = HW'(HBLK_P + 4);
   localparam logic [HW-1:0] ACTB_N = HW'(HBLK_N + 8);
   localparam logic [HW-1:0] ACTB_P = HW'(HBLK_P + 8);

   localparam logic [VW-1:0] TOT_N = VW'(N_LINES);
   localparam logic [VW-1:0] TOT_P = VW'(P_LINES);

   logic [HW-1:0] hcnt;
   logic [VW-1:0] lnum;
   logic [HW-1:0] last_b, sav_b, act_b;
   logic [VW-1:0] tot, fs, fe, a1, b1, a2, b2;
   logic          line_end;

   // per-format constants
   always_comb begin
      if (fmt_q) begin
         last_b = LAST_P;  sav_b = SAVB_P;  act_b = ACTB_P;  tot = TOT_P;
         fs = VW'(P_FS);  fe = VW'(P_FE);  a1 = VW'(P_A1);
         b1 = VW'(P_B1);  a2 = VW'(P_A2);  b2 = VW'(P_B2);
      end else begin
         last_b = LAST_N;  sav_b = SAVB_N;  act_b = ACTB_N;  tot = TOT_N;
         fs = VW'(N_FS);  fe = VW'(N_FE);  a1 = VW'(N_A1);
         b1 = VW'(N_B1);  a2 = VW'(N_A2);  b2 = VW'(N_B2);
      end
   end

   assign line_end  = (hcnt == last_b);
   assign frame_end = line_end && (lnum == tot);

   assign f_bit = (lnum >= fs) || (lnum < fe);
   assign v_bit = (lnum < a1) || ((lnum >= b1) && (lnum < a2)) || (lnum >= b2);

   always_comb begin
      if (hcnt < HW'(4)) begin
         zone = Z_EAV;
         ofs  = hcnt;
      end else if (hcnt < sav_b) begin
         zone = Z_BLANK;
         ofs  = hcnt;
      end else if (hcnt < act_b) begin
         zone = Z_SAV;
         ofs  = hcnt - sav_b;
      end else begin
         zone = Z_ACT;
         ofs  = hcnt - act_b;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hcnt  <= '0;
         lnum  <= VW'(1);
         fmt_q <= 1'b0;
         pat_q <= 4'd0;
      end else if (line_end) begin
         hcnt <= '0;
         if (lnum == tot) begin
            lnum  <= VW'(1);
            fmt_q <= fmt_in;
            pat_q <= pat_in;
         end else begin
            lnum <= lnum + 1'b1;
         end
      end else begin
         hcnt <= hcnt + 1'b1;
      end
   end

   AST_LATCH_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({fmt_q, pat_q}) |-> $past(frame_end)) else $error("settings changed mid-frame"); // R13
   AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (lnum >= VW'(1)) && (lnum <= tot)) else $error("line number out of frame"); // R3

endmodule

// File: rtl/vpat656_pattern.sv
module vpat656_pattern
   import vpat656_pkg::*;
#(
   parameter int ACT_PIX = 720,
   parameter int PW      = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [3:0]    pat,
   input  logic [PW-1:0] ypix,
   input  logic [PW-1:0] cpix,
   output logic [7:0]    y,
   output logic [7:0]    cb,
   output logic [7:0]    cr
);

   localparam int BW  = ACT_PIX / 8;
   localparam int RW  = PW + 5;
   localparam logic [PW-1:0] HALF = PW'(ACT_PIX / 2);

   ycc_t       bar_l, bar_c;
   logic [7:0] ramp_y [4];

   assign bar_l = bar_color(3'(ypix / BW));
   assign bar_c = bar_color(3'(cpix / BW));

   // one ramp per slope: Y = 16 + (p << g) / 2, ceiling at 235
   for (genvar g = 0; g < 4; g++) begin : g_ramp
      logic [RW-1:0] sum;
      assign sum       = RW'(Y_BLK) + ((RW'(ypix) << g) >> 1);
      assign ramp_y[g] = (sum > RW'(Y_MAX)) ? Y_MAX : sum[7:0];
   end

   always_comb begin
      y  = Y_BLK;
      cb = C_MID;
      cr = C_MID;
      if (!pat[3]) begin
         unique case (pat[2:0])
            3'd0: begin
               y  = bar_l.y;
               cb = bar_c.cb;
               cr = bar_c.cr;
            end
            3'd1: y = bar_l.y;
            3'd2: y = (ypix < HALF) ? Y_BLK : Y_STEP_HI;
            3'd3: begin
               y  = 8'd123;
               cb = 8'd154;
               cr = 8'd50;
            end
            3'd4: y = ramp_y[0];
            3'd5: y = ramp_y[1];
            3'd6: y = ramp_y[2];
            default: y = ramp_y[3];
         endcase
      end
   end

   AST_RAMP_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
      (!pat[3] && pat[2]) |-> ((y >= Y_BLK) && (y <= Y_MAX))) else $error("ramp outside range"); // R10

endmodule

// File: rtl/vpat656_gen.sv
module vpat656_gen
   import vpat656_pkg::*;
#(
   parameter int ACT_PIX = 720,
   parameter int HBLK_N  = 268,
   parameter int HBLK_P  = 280,
   parameter int N_LINES = 525,
   parameter int N_FS    = 266,
   parameter int N_FE    = 4,
   parameter int N_A1    = 20,
   parameter int N_B1    = 264,
   parameter int N_A2    = 283,
   parameter int N_B2    = 526,
   parameter int P_LINES = 625,
   parameter int P_FS    = 313,
   parameter int P_FE    = 1,
   parameter int P_A1    = 23,
   parameter int P_B1    = 311,
   parameter int P_A2    = 336,
   parameter int P_B2    = 624
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] pat_sel,
   input  logic       fmt_pal,
   output logic [7:0] dout
);

   localparam int LEN_MAX = 2 * ACT_PIX + ((HBLK_N > HBLK_P) ? HBLK_N : HBLK_P) + 8;
   localparam int LIN_MAX = (N_LINES > P_LINES) ? N_LINES : P_LINES;
   localparam int HW      = $clog2(LEN_MAX);
   localparam int VW      = $clog2(LIN_MAX + 2);
   localparam int PW      = $clog2(ACT_PIX);

   // elaboration-time parameter checks
   if (ACT_PIX % 16 != 0) begin : g_chk_act
      $error("ACT_PIX must be a multiple of 16");
   end
   if ((HBLK_N % 2 != 0) || (HBLK_P % 2 != 0)) begin : g_chk_hb
      $error("horizontal blanking must be an even byte count");
   end
   if (!((N_A1 <= N_B1) && (N_B1 <= N_A2) && (N_A2 <= N_B2) && (N_B2 <= N_LINES + 1))) begin : g_chk_vn
      $error("525-line vertical boundaries out of order");
   end
   if (!((P_A1 <= P_B1) && (P_B1 <= P_A2) && (P_A2 <= P_B2) && (P_B2 <= P_LINES + 1))) begin : g_chk_vp
      $error("625-line vertical boundaries out of order");
   end

   logic          fmt_q;
   logic [3:0]    pat_q;
   zone_e         zone;
   logic [HW-1:0] ofs;
   logic          f_bit, v_bit, frame_end;
   logic [PW-1:0] ypix, cpix;
   logic [7:0]    y_s, cb_s, cr_s;
   logic [7:0]    raw, nxt;

   vpat656_timing #(
      .ACT_PIX(ACT_PIX), .HBLK_N(HBLK_N), .HBLK_P(HBLK_P),
      .N_LINES(N_LINES), .N_FS(N_FS), .N_FE(N_FE), .N_A1(N_A1), .N_B1(N_B1),
      .N_A2(N_A2), .N_B2(N_B2),
      .P_LINES(P_LINES), .P_FS(P_FS), .P_FE(P_FE), .P_A1(P_A1), .P_B1(P_B1),
      .P_A2(P_A2), .P_B2(P_B2),
      .HW(HW), .VW(VW)
   ) i_timing (
      .clk      (clk),
      .rst_n    (rst_n),
      .fmt_in   (fmt_pal),
      .pat_in   (pat_sel),
      .fmt_q    (fmt_q),
      .pat_q    (pat_q),
      .zone     (zone),
      .ofs      (ofs),
      .f_bit    (f_bit),
      .v_bit    (v_bit),
      .frame_end(frame_end)
   );

   assign ypix = PW'(ofs >> 1);
   assign cpix = PW'((ofs >> 2) << 1);

   vpat656_pattern #(
      .ACT_PIX(ACT_PIX), .PW(PW)
   ) i_pattern (
      .clk  (clk),
      .rst_n(rst_n),
      .pat  (pat_q),
      .ypix (ypix),
      .cpix (cpix),
      .y    (y_s),
      .cb   (cb_s),
      .cr   (cr_s)
   );

   always_comb begin
      unique case (ofs[1:0])
         2'd0:    raw = cb_s;
         2'd2:    raw = cr_s;
         default: raw = y_s;
      endcase
   end

   always_comb begin
      nxt = C_MID;
      unique case (zone)
         Z_EAV, Z_SAV: begin
            unique case (ofs[1:0])
               2'd0:    nxt = 8'hFF;
               2'd3:    nxt = xy_code(f_bit, v_bit, zone == Z_EAV);
               default: nxt = 8'h00;
            endcase
         end
         Z_BLANK: nxt = ofs[0] ? Y_BLK : C_MID;
         default: nxt = v_bit ? (ofs[0] ? Y_BLK : C_MID) : sample_clamp(raw);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) dout <= C_MID;
      else        dout <= nxt;
   end

   AST_EAV_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (zone == Z_EAV && ofs == '0) |=> (dout == 8'hFF)) else $error("line does not open with FF"); // R1
   AST_XY_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dout, 3) == 8'hFF && $past(dout, 2) == 8'h00 && $past(dout, 1) == 8'h00)
      |-> (dout[7] && dout[3:0] == {dout[5] ^ dout[4], dout[6] ^ dout[4],
                                    dout[6] ^ dout[5], dout[6] ^ dout[5] ^ dout[4]}))
      else $error("bad status word protection"); // R2
   AST_ACT_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (zone == Z_ACT && !v_bit) |=> (dout != 8'h00 && dout != 8'hFF)) else $error("reserved value in active"); // R12

endmodule

// File: tb/test_vpat656_gen.sv
module test_vpat656_gen;

   localparam int ACT = 64;
   localparam int HBN = 12;
   localparam int HBP = 16;
   localparam int NF  = 12;

   // frame plan: format and code of each frame
   localparam bit FRM_FMT [NF] = '{0, 1, 0, 1, 0, 1, 0, 1, 0, 1, 0, 1};
   localparam int FRM_PAT [NF] = '{0, 1, 0, 0, 1, 2, 3, 4, 5, 6, 7, 9};

   localparam int BAR_Y  [8] = '{169, 152, 123, 106, 79, 62, 33, 16};
   localparam int BAR_CB [8] = '{128, 50, 154, 76, 180, 102, 206, 128};
   localparam int BAR_CR [8] = '{128, 141, 50, 62, 194, 206, 115, 128};

   typedef struct packed {
      logic [7:0] v;
      logic [3:0] tag;
      logic       act;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] pat_sel = 4'd1;
   logic       fmt_pal = 1'b1;
   logic [7:0] dout;

   item_t q[$];
   int    checks = 0;
   int    errors = 0;
   bit    mon_en = 1'b0;
   bit    done = 1'b0;

   always #10 clk = ~clk;

   vpat656_gen #(
      .ACT_PIX(ACT), .HBLK_N(HBN), .HBLK_P(HBP),
      .N_LINES(9),  .N_FS(6), .N_FE(2), .N_A1(3), .N_B1(5), .N_A2(7), .N_B2(10),
      .P_LINES(11), .P_FS(6), .P_FE(1), .P_A1(3), .P_B1(6), .P_A2(8), .P_B2(11)
   ) i_vpat656_gen (
      .clk    (clk),
      .rst_n  (rst_n),
      .pat_sel(pat_sel),
      .fmt_pal(fmt_pal),
      .dout   (dout)
   );

   function automatic string tname(input int t);
      case (t)
         1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
         5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
         9: return "R9";   10: return "R10"; 11: return "R11"; 12: return "R12";
         default: return "R13";
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: dout=%02h expected %02h at %0t", tag, got, exp, $time);
      end
   endtask

   // R3 frame geometry as scaled for this bench
   function automatic int lines_of(input bit fmt);
      return fmt ? 11 : 9;
   endfunction
   function automatic int len_of(input bit fmt);
      return 2 * ACT + (fmt ? HBP : HBN) + 8;
   endfunction
   function automatic bit fb(input bit fmt, input int l);
      return fmt ? (l >= 6) : (l >= 6 || l < 2);
   endfunction
   function automatic bit vb(input bit fmt, input int l);
      return fmt ? (l < 3 || (l >= 6 && l < 8) || l >= 11) : (l < 3 || (l >= 5 && l < 7));
   endfunction

   function automatic int ey(input int pat, input int p);
      int r;
      if (pat >= 8) return 16;
      case (pat)
         0, 1: return BAR_Y[p / (ACT / 8)];
         2: return (p < ACT / 2) ? 16 : 169;
         3: return 123;
         default: begin
            r = 16 + (p * (1 << (pat - 4))) / 2;
            return (r > 235) ? 235 : r;
         end
      endcase
   endfunction
   function automatic int ecb(input int pat, input int p);
      if (pat == 0) return BAR_CB[p / (ACT / 8)];
      if (pat == 3) return 154;
      return 128;
   endfunction
   function automatic int ecr(input int pat, input int p);
      if (pat == 0) return BAR_CR[p / (ACT / 8)];
      if (pat == 3) return 50;
      return 128;
   endfunction

   function automatic logic [7:0] code_byte(input int k, input bit f, input bit v, input bit h);
      case (k)
         0: return 8'hFF;
         3: return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ (v ^ h)};
         default: return 8'h00;
      endcase
   endfunction

   task automatic push_frame(input bit fmt, input int pat, input bit r13);
      int    hb, a, k, ptag;
      bit    f, v;
      item_t it;
      hb = fmt ? HBP : HBN;
      for (int l = 1; l <= lines_of(fmt); l++) begin
         f = fb(fmt, l);
         v = vb(fmt, l);
         for (int h = 0; h < len_of(fmt); h++) begin
            it.act = 1'b0;
            if (h < 4) begin
               it.v   = code_byte(h, f, v, 1'b1);
               it.tag = (h == 3) ? 4'd2 : 4'd1;
            end else if (h < 4 + hb) begin
               it.v   = (h % 2 == 1) ? 8'h10 : 8'h80;
               it.tag = 4'd4;
            end else if (h < 8 + hb) begin
               k      = h - 4 - hb;
               it.v   = code_byte(k, f, v, 1'b0);
               it.tag = (k == 3) ? 4'd3 : 4'd1;
            end else if (v) begin
               it.v   = (h % 2 == 1) ? 8'h10 : 8'h80;
               it.tag = 4'd4;
            end else begin
               a      = h - 8 - hb;
               it.act = 1'b1;
               case (a % 4)
                  0: it.v = 8'(ecb(pat, (a / 4) * 2));
                  2: it.v = 8'(ecr(pat, (a / 4) * 2));
                  default: it.v = 8'(ey(pat, a / 2));
               endcase
               if (pat >= 8) ptag = 11;
               else if (pat == 0) ptag = (a % 2 == 0) ? 5 : 6;
               else if (pat == 1) ptag = 7;
               else if (pat == 2) ptag = 8;
               else if (pat == 3) ptag = 9;
               else ptag = 10;
               it.tag = r13 ? 4'd13 : 4'(ptag);
            end
            q.push_back(it);
         end
      end
   endtask

   // monitor: pop one expected byte per clock and compare
   always @(negedge clk) begin
      item_t it;
      if (mon_en) begin
         if (q.size() == 0) begin
            chk(1'b0, "R1", dout, 8'h00);
         end else begin
            it = q.pop_front();
            chk(dout === it.v, tname(int'(it.tag)), dout, it.v);
            if (it.act) chk(dout !== 8'h00 && dout !== 8'hFF, "R12", dout, it.v);
         end
      end
   end

   initial begin
      int plen;
      repeat (5) @(negedge clk);
      chk(dout === 8'h80, "R13", dout, 8'h80);
      push_frame(1'b0, 0, 1'b1);
      plen = len_of(1'b0) * lines_of(1'b0);
      rst_n = 1'b1;
      @(posedge clk);
      mon_en = 1'b1;
      for (int i = 1; i < NF; i++) begin
         while (q.size() > plen - 20) @(posedge clk);
         @(negedge clk);
         fmt_pal = ~FRM_FMT[i];
         pat_sel = 4'hC;
         repeat (30) @(negedge clk);
         fmt_pal = FRM_FMT[i];
         pat_sel = 4'(FRM_PAT[i]);
         while (q.size() > 10) @(posedge clk);
         push_frame(FRM_FMT[i], FRM_PAT[i], i == 1);
         plen = len_of(FRM_FMT[i]) * lines_of(FRM_FMT[i]);
      end
      while (q.size() > 0) @(posedge clk);
      mon_en = 1'b0;
      done = 1'b1;
      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R13: watchdog expired, %0d bytes pending expected 0", q.size());
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule